// File: doc/BRIEF.md
# Receive Parallel Output Clock Formatter

This block sits between a deserializer's word aligner and the parallel receive pins. Every `TICKS` cycles of a fast internal clock the aligner hands over one 10-bit code group, pulsed by `word_stb`. The group arrives with a flag that marks the comma-carrying word. The block turns that word stream into one of three parallel formats, together with matching byte clocks. Both the byte clocks and the data are registered outputs. Clock edges are placed so that each capturing edge falls in the middle of the interval in which the data is stable.

Two static pins choose the format:
- **Full-rate:** a single byte clock with one rising edge per word.
- **Half-rate:** two byte clocks in antiphase, each at half the word rate, with words tied alternately to each clock. The word that starts a burst always goes to the second clock.
- **Double-edge:** five pins, with half a word on each edge of the first byte clock.

Changing the format pins restarts the clock pattern cleanly from an all-low state.

Top module: `rxfmt_top`

## Requirements
- R1: Format decode: `mode_sel`=0 with `rate_sel`=0 selects half-rate, `mode_sel`=0 with `rate_sel`=1 selects full-rate, and `mode_sel`=1 selects double-edge whatever `rate_sel` is. A `rate_sel` change while `mode_sel`=1 neither interrupts nor alters the output stream.
- R2: After reset, `bclk0` and `bclk1` stay low and `rxd` and `rx_sync` stay zero until the first `word_stb`.
- R3: In full-rate mode, `bclk0` has one rising edge per word and that edge captures the word on `rxd[9:0]`. `bclk1` stays low.
- R4: In half-rate mode, `bclk0` and `bclk1` each run at half the word rate in antiphase. Successive words are captured alternately by their rising edges.
- R5: In half-rate mode, the first word after reset or after a format change is captured by the rising edge of `bclk1`. `bclk0` stays low during that word.
- R6: In double-edge mode, the rising edge of `bclk0` captures word bits [4:0] on `rxd[4:0]`, and the following falling edge captures bits [9:5] on the same pins. `rxd[9:5]` and `bclk1` stay low.
- R7: `rx_sync` carries the flag of the word being captured, and is sampled on the same edge as that word (the rising edge in double-edge mode).
- R8: A change of the decoded format drives both clocks low and all data outputs to zero in the cycle after the change, until the next `word_stb`.
- R9: Data is stable on every capturing edge. In full-rate mode, `bclk0` stays high for `TICKS`/2 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast internal clock, `TICKS` cycles per word |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 1 | 1 selects the 5-bit double-edge format |
| rate_sel | input | 1 | With `mode_sel`=0: 1 full-rate, 0 half-rate |
| word_stb | input | 1 | One-cycle pulse per aligned word |
| word_in | input | 10 | Aligned code group, bit 0 received first |
| word_sync | input | 1 | Word carries the comma character |
| bclk0 | output | 1 | First byte clock |
| bclk1 | output | 1 | Second byte clock (half-rate only) |
| rxd | output | 10 | Parallel receive data |
| rx_sync | output | 1 | Comma marker aligned with `rxd` |

## Verification
The hardest situation to reach is a `rate_sel` toggle in the middle of a word while the double-edge format is active. There the decoder must treat the pin as a no-op, where a sloppy design would resynchronise and silently drop a word. The stimulus flips `rate_sel` halfway through a double-edge burst. It then requires that every word of the burst is captured intact, with the count matching. Reset pulses and format changes between bursts also force the half-rate first-word rule to be checked repeatedly, with random burst lengths.

// File: rtl/rxfmt_pkg.sv
package rxfmt_pkg;

  typedef enum logic [1:0] {
    FMT_HALF = 2'd0,
    FMT_FULL = 2'd1,
    FMT_DDR  = 2'd2
  } fmt_e;

  // mode_sel has priority; rate_sel only matters on the 10-bit bus
  function automatic fmt_e fmt_decode(input logic msel, input logic rsel);
    if (msel)      return FMT_DDR;
    else if (rsel) return FMT_FULL;
    return FMT_HALF;
  endfunction

endpackage

// File: rtl/rxfmt_mode_track.sv
module rxfmt_mode_track
  import rxfmt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic mode_sel,
  input  logic rate_sel,
  output fmt_e fmt_now,
  output fmt_e fmt_q,
  output logic resync
);

  assign fmt_now = fmt_decode(mode_sel, rate_sel);

  always_ff @(posedge clk) begin
    fmt_q <= fmt_now;
  end

  // only a change of the decoded format restarts the clocks
  assign resync = !rst && (fmt_now != fmt_q);

  // R1: rate pin toggling in double-edge mode never restarts anything
  p_ddr_rate_ignored_r1: assert property (@(posedge clk) disable iff (rst)
    (fmt_q == FMT_DDR && mode_sel) |-> !resync);

endmodule

// File: rtl/rxfmt_phase.sv
module rxfmt_phase #(
  parameter int TICKS = 8,
  localparam int PW = $clog2(TICKS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          resync,
  input  logic          word_stb,
  output logic          nx_active,
  output logic [PW-1:0] nx_ph,
  output logic          nx_slot,
  output logic          nx_first,
  output logic          act_q,
  output logic          first_q
);

  localparam logic [PW-1:0] LAST = PW'(TICKS - 1);

  logic [PW-1:0] ph_q;
  logic          slot_q;

  always_comb begin
    nx_active = act_q;
    nx_ph     = ph_q;
    nx_slot   = slot_q;
    nx_first  = first_q;
    if (resync) begin
      nx_active = 1'b0;
      nx_ph     = '0;
      nx_slot   = 1'b0;
      nx_first  = 1'b0;
    end else if (word_stb) begin
      nx_active = 1'b1;
      nx_ph     = '0;
      nx_slot   = act_q ? !slot_q : 1'b0;
      nx_first  = !act_q;
    end else if (act_q) begin
      if (ph_q == LAST) begin
        nx_ph    = '0;
        nx_slot  = !slot_q;
        nx_first = 1'b0;
      end else begin
        nx_ph = ph_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q   <= 1'b0;
      ph_q    <= '0;
      slot_q  <= 1'b0;
      first_q <= 1'b0;
    end else begin
      act_q   <= nx_active;
      ph_q    <= nx_ph;
      slot_q  <= nx_slot;
      first_q <= nx_first;
    end
  end

  // R2: a strobe with no format change starts a word window at phase zero
  p_stb_restart_r2: assert property (@(posedge clk) disable iff (rst)
    (word_stb && !resync) |=> (act_q && ph_q == '0));

  // R5: the first word of a burst always sits in the second-clock slot
  p_first_slot_r5: assert property (@(posedge clk) disable iff (rst)
    first_q |-> !slot_q);

endmodule

// File: rtl/rxfmt_lanes.sv
module rxfmt_lanes
  import rxfmt_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int TICKS  = 8,
  localparam int PW     = $clog2(TICKS),
  localparam int HALF_W = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  fmt_e              fmt_now,
  input  fmt_e              fmt_q,
  input  logic              word_stb,
  input  logic [DATA_W-1:0] word_in,
  input  logic              word_sync,
  input  logic              nx_active,
  input  logic [PW-1:0]     nx_ph,
  input  logic              nx_slot,
  input  logic              nx_first,
  input  logic              act_q,
  input  logic              first_q,
  output logic              bclk0,
  output logic              bclk1,
  output logic [DATA_W-1:0] rxd,
  output logic              rx_sync
);

  localparam logic [PW-1:0] HT = PW'(TICKS / 2);
  localparam logic [PW-1:0] QT = PW'(TICKS / 4);
  localparam logic [PW-1:0] TQ = PW'((3 * TICKS) / 4);

  logic [DATA_W-1:0] word_q, nx_word, d_nx;
  logic              sync_q, nx_sync, b0_nx, b1_nx, s_nx;

  assign nx_word = word_stb ? word_in : word_q;
  assign nx_sync = word_stb ? word_sync : sync_q;

  always_comb begin
    b0_nx = 1'b0;
    b1_nx = 1'b0;
    d_nx  = '0;
    s_nx  = 1'b0;
    if (nx_active) begin
      s_nx = nx_sync;
      unique case (fmt_now)
        FMT_FULL: begin
          b0_nx = (nx_ph >= HT);
          d_nx  = nx_word;
        end
        FMT_HALF: begin
          d_nx = nx_word;
          if (!nx_slot) begin
            b1_nx = (nx_ph >= HT);
            b0_nx = (nx_ph < HT) && !nx_first;
          end else begin
            b0_nx = (nx_ph >= HT);
            b1_nx = (nx_ph < HT);
          end
        end
        FMT_DDR: begin
          b0_nx = (nx_ph >= QT) && (nx_ph < TQ);
          d_nx[HALF_W-1:0] = (nx_ph < HT) ? nx_word[HALF_W-1:0]
                                          : nx_word[DATA_W-1:HALF_W];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q  <= '0;
      sync_q  <= 1'b0;
      bclk0   <= 1'b0;
      bclk1   <= 1'b0;
      rxd     <= '0;
      rx_sync <= 1'b0;
    end else begin
      word_q  <= nx_word;
      sync_q  <= nx_sync;
      bclk0   <= b0_nx;
      bclk1   <= b1_nx;
      rxd     <= d_nx;
      rx_sync <= s_nx;
    end
  end

  // R2 / R8: idle means everything low
  p_idle_zero_r2: assert property (@(posedge clk) disable iff (rst)
    !act_q |-> (!bclk0 && !bclk1 && rxd == '0 && !rx_sync));

  // R3 / R6: second clock quiet outside half-rate
  p_bclk1_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (fmt_q != FMT_HALF) |-> !bclk1);

  // R4: antiphase once the first word window has passed
  p_antiphase_r4: assert property (@(posedge clk) disable iff (rst)
    (fmt_q == FMT_HALF && act_q && !first_q) |-> (bclk0 != bclk1));

  // R5: first clock held low through the first half-rate word
  p_first_on_clk1_r5: assert property (@(posedge clk) disable iff (rst)
    (fmt_q == FMT_HALF && first_q) |-> !bclk0);

  // R6: upper pins unused in double-edge mode
  p_upper_low_r6: assert property (@(posedge clk) disable iff (rst)
    (fmt_q == FMT_DDR) |-> (rxd[DATA_W-1:HALF_W] == '0));

  // R9: data never moves on a capturing rising edge
  p_stable_rise_r9: assert property (@(posedge clk) disable iff (rst)
    ($rose(bclk0) || $rose(bclk1)) |-> ($stable(rxd) && $stable(rx_sync)));

  // R9: second half steady at the double-edge falling edge
  p_stable_fall_r9: assert property (@(posedge clk) disable iff (rst)
    (fmt_q == FMT_DDR && $fell(bclk0) && act_q) |-> $stable(rxd));

endmodule

// File: rtl/rxfmt_top.sv
module rxfmt_top
  import rxfmt_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int TICKS  = 8,
  localparam int PW    = $clog2(TICKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_sel,
  input  logic              rate_sel,
  input  logic              word_stb,
  input  logic [DATA_W-1:0] word_in,
  input  logic              word_sync,
  output logic              bclk0,
  output logic              bclk1,
  output logic [DATA_W-1:0] rxd,
  output logic              rx_sync
);

  fmt_e          fmt_now, fmt_q;
  logic          resync, nx_active, nx_slot, nx_first, act_q, first_q;
  logic [PW-1:0] nx_ph;

  rxfmt_mode_track u_mode (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .rate_sel(rate_sel),
    .fmt_now(fmt_now), .fmt_q(fmt_q), .resync(resync)
  );

  rxfmt_phase #(.TICKS(TICKS)) u_phase (
    .clk(clk), .rst(rst), .resync(resync), .word_stb(word_stb),
    .nx_active(nx_active), .nx_ph(nx_ph), .nx_slot(nx_slot),
    .nx_first(nx_first), .act_q(act_q), .first_q(first_q)
  );

  rxfmt_lanes #(.DATA_W(DATA_W), .TICKS(TICKS)) u_lanes (
    .clk(clk), .rst(rst), .fmt_now(fmt_now), .fmt_q(fmt_q),
    .word_stb(word_stb), .word_in(word_in), .word_sync(word_sync),
    .nx_active(nx_active), .nx_ph(nx_ph), .nx_slot(nx_slot),
    .nx_first(nx_first), .act_q(act_q), .first_q(first_q),
    .bclk0(bclk0), .bclk1(bclk1), .rxd(rxd), .rx_sync(rx_sync)
  );

endmodule

// File: tb/rxfmt_top_tb.sv
`timescale 1ns/1ps
module rxfmt_top_tb;
  localparam int T = 8;
  localparam int H = T / 2;
  localparam logic [9:0] COMMA = 10'b0011111010;

  logic clk = 0, rst = 1, mode_sel = 0, rate_sel = 0, word_stb = 0, word_sync = 0;
  logic [9:0] word_in = '0;
  logic bclk0, bclk1, rx_sync;
  logic [9:0] rxd;

  rxfmt_top #(.DATA_W(10), .TICKS(T)) u_dut (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .rate_sel(rate_sel),
    .word_stb(word_stb), .word_in(word_in), .word_sync(word_sync),
    .bclk0(bclk0), .bclk1(bclk1), .rxd(rxd), .rx_sync(rx_sync)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0, n_bad = 0, exp_n = 0, cap_n = 0, mmode = 0, hi_cnt = 0;
  bit mon_en = 0, done = 0, c1_seen = 0;
  logic [9:0] ew [64];
  logic       es [64];
  logic p0 = 0, p1 = 0, lo_s = 0;
  logic [4:0] lo = '0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cap_word(input logic [9:0] w, input logic s, input string tag);
    if (cap_n < exp_n) begin
      chk(w == ew[cap_n], tag, 32'(w), 32'(ew[cap_n]));
      chk(s == es[cap_n], "R7 sync flag", 32'(s), 32'(es[cap_n]));
    end
    cap_n++;
  endtask

  // receiver model: samples pins between clock edges
  always @(negedge clk) begin
    if (mon_en) begin
      if (mmode != 0 && bclk1) c1_seen = 1;
      if (mmode == 1) begin
        if (bclk0 && !p0) cap_word(rxd, rx_sync, "R3 full-rate word");
        if (bclk0) hi_cnt++;
        if (!bclk0 && p0) begin
          chk(hi_cnt == H, "R9 bclk0 high time", 32'(hi_cnt), 32'(H));
          hi_cnt = 0;
        end
      end else if (mmode == 0) begin
        if (bclk0 && !p0 && bclk1 && !p1) chk(0, "R4 simultaneous rise", 1, 0);
        if (bclk1 && !p1) begin
          if (cap_n < exp_n)
            chk(cap_n % 2 == 0, cap_n == 0 ? "R5 first word on bclk1" : "R4 even word on bclk1",
                32'(cap_n), 32'(cap_n & ~1));
          cap_word(rxd, rx_sync, "R4 half-rate word");
        end
        if (bclk0 && !p0) begin
          if (cap_n < exp_n) chk(cap_n % 2 == 1, "R4 odd word on bclk0", 32'(cap_n), 32'(cap_n | 1));
          cap_word(rxd, rx_sync, "R4 half-rate word");
        end
      end else begin
        if (bclk0 && !p0) begin
          lo = rxd[4:0];
          lo_s = rx_sync;
          if (cap_n < exp_n) chk(rxd[9:5] == 0, "R6 upper pins low", 32'(rxd[9:5]), 0);
        end
        if (!bclk0 && p0) cap_word({rxd[4:0], lo}, lo_s, "R6 double-edge word");
      end
      p0 = bclk0;
      p1 = bclk1;
    end
  end

  task automatic check_idle(input string req);
    chk(!bclk0 && !bclk1 && rxd == 0 && !rx_sync, req, {20'd0, bclk0, bclk1, rxd}, 0);
  endtask

  task automatic set_mode(input int md);
    mode_sel = (md == 2);
    rate_sel = (md == 1) ? 1'b1 : (md == 2) ? 1'($urandom) : 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check_idle("R2 reset idle");
  endtask

  task automatic stream(input int md, input int n, input bit toggle_rate);
    mmode = md; cap_n = 0; exp_n = n; p0 = 0; p1 = 0; hi_cnt = 0; c1_seen = 0;
    for (int i = 0; i < n; i++) begin
      ew[i] = (i == 0) ? COMMA : 10'($urandom);
      es[i] = (i == 0) || ($urandom % 8 == 0);
    end
    mon_en = 1;
    repeat ($urandom % 4) @(negedge clk);
    check_idle("R2 idle before first word");
    for (int i = 0; i < n; i++) begin
      word_stb = 1; word_in = ew[i]; word_sync = es[i];
      @(negedge clk);
      word_stb = 0; word_in = 10'($urandom); word_sync = 1'($urandom);
      if (toggle_rate && i == n / 2) rate_sel = ~rate_sel;
      repeat (T - 1) @(negedge clk);
    end
    repeat (T) @(negedge clk);
    mon_en = 0;
    chk(cap_n >= n, toggle_rate ? "R1 rate pin ignored, capture count" : "R4 capture count",
        32'(cap_n), 32'(n));
    if (md != 0) chk(!c1_seen, md == 1 ? "R3 bclk1 low" : "R6 bclk1 low", 32'(c1_seen), 0);
  endtask

  task automatic change_mode(input int md);
    @(negedge clk) set_mode(md);
    @(negedge clk);
    check_idle("R8 zero after format change");
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    set_mode(0);
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check_idle("R2 reset idle");
    stream(0, 20, 0);
    change_mode(1);
    stream(1, 20, 0);
    change_mode(2);
    stream(2, 24, 1);
    change_mode(0);
    stream(0, 7, 0);
    for (int k = 0; k < 12; k++) begin
      int md;
      md = $urandom % 3;
      @(negedge clk) set_mode(md);
      do_reset();
      stream(md, 3 + $urandom % 30, md == 2);
    end
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule